// File: doc/BRIEF.md
# Masked Level Interrupt Collector with Vector Readout

This block merges sixteen level-sensitive interrupt requests into a single request line for a processor. Each request input passes through a two-stage synchronizer, and the synchronized level is ANDed with a software-programmed enable mask to form the set of pending sources. The request line is high while at least one pending bit is set.

Software reaches the block through a 16-bit register port with two registers. The vector register is read-only. It reports the lowest-numbered pending source i as (i+1)<<2, and it reads zero when nothing is pending, so a handler can use the value directly as a table offset. The mask register reads back and can be written. Pending state follows the inputs: it is never stored apart from them, and reading the vector leaves it as it was.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the mask register reads 0x0010, the vector reads 0x0000 and irq_out is low.
- R2: A source's pending bit follows its input level. Releasing the input clears the pending bit, and the block keeps no sticky record of it.
- R3: irq_out is high exactly when (synchronized inputs AND mask) is nonzero.
- R4: A read at offset 0x000 returns (i+1)<<2, where i is the lowest bit index set in (synchronized inputs AND mask). Bit 0 has the highest priority and bit 15 the lowest.
- R5: The vector reads 0x0000 when no source is pending, including when inputs are high but masked off.
- R6: A write at offset 0x002 (reg_we high) loads reg_wdata into the mask at that clock edge. Offset 0x002 reads the mask back, and irq_out reflects the new mask in the cycle after the write edge.
- R7: Reads at any offset other than 0x000 and 0x002 return 0x0000. Writes to any offset other than 0x002, including the read-only vector offset 0x000, change neither the mask nor the vector.
- R8: Reading the vector register any number of times does not change the vector or irq_out.
- R9: A change on an input reaches the pending state and irq_out after exactly two rising clock edges. After only one edge the outputs still show the old level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 16 | Level-sensitive interrupt requests, bit 0 highest priority |
| reg_addr | input | 12 | Register byte offset |
| reg_we | input | 1 | Write strobe, sampled at the rising edge |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| irq_out | output | 1 | Merged interrupt request line |

## Verification
A corrupted mask bit shows up at the mask readback on the next read. It also shows on irq_out and in the vector as soon as an input at that position is raised, two edges later. A synchronizer stage that is stuck or skipped shifts the latency that R9 observes by one cycle, and a stuck stage also leaves a released input still pending. An encoder with the wrong priority direction or the wrong offset gives a wrong vector on the first multi-source pattern, without waiting.

// File: rtl/irq_agg_pkg.sv
// Shared constants and types for the masked interrupt collector.
// Assumes one 16-bit register port and byte-addressed offsets.
package irq_agg_pkg;
    localparam int unsigned SRC_N    = 16;
    localparam int unsigned DATA_W   = 16;
    localparam int unsigned ADDR_W   = 12;
    localparam int unsigned VEC_SHL  = 2;
    localparam logic [DATA_W-1:0] MASK_RST = 16'h0010;

    typedef enum logic [1:0] {
        SEL_VEC  = 2'd0,
        SEL_MASK = 2'd1,
        SEL_NONE = 2'd2
    } reg_sel_e;
endpackage

// File: rtl/irq_sync_bank.sv
// Multi-stage synchronizer bank for asynchronous level inputs.
// Assumes each bit is an independent level; there is no cross-bit coherence.
module irq_sync_bank #(
    parameter int unsigned WIDTH  = 16,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage: capture the raw inputs
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= async_in;
                end
            end else begin : g_next
                // Later stage: pass the previous stage along
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/irq_mask_reg.sv
// Enable mask register with a reset value given by a parameter.
// Assumes the write enable is already decoded for this register.
module irq_mask_reg #(
    parameter int unsigned WIDTH = 16,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] mask_q
);
    // Hold the mask; load it on a decoded write
    always_ff @(posedge clk) begin
        if (!rst_n)     mask_q <= RST_VAL;
        else if (wr_en) mask_q <= wr_data;
    end
endmodule

// File: rtl/irq_vec_enc.sv
// Fixed-priority vector encoder: the lowest set index wins.
// Output is ((index+1) << SHL), or zero when no bit is set. Assumes OUT_W can hold (N << SHL).
module irq_vec_enc #(
    parameter int unsigned N     = 16,
    parameter int unsigned OUT_W = 16,
    parameter int unsigned SHL   = 2
) (
    input  logic [N-1:0]     req,
    output logic [OUT_W-1:0] vec
);
    // Scan from the top down so that the lowest index is written last
    always_comb begin
        vec = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) vec = OUT_W'((i + 1) << SHL);
        end
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
// Top of the masked interrupt collector: synchronizer, mask, encoder, register mux.
// Assumes full-address decode on 16-bit accesses; offsets that are not decoded read zero.
module irq_vector_ctrl
    import irq_agg_pkg::*;
#(
    parameter int unsigned N        = SRC_N,
    parameter int unsigned DW       = DATA_W,
    parameter int unsigned AW       = ADDR_W,
    parameter int unsigned SYNC_STG = 2,
    parameter logic [AW-1:0] VEC_OFF  = 12'h000,
    parameter logic [AW-1:0] MASK_OFF = 12'h002
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  irq_in,
    input  logic [AW-1:0] reg_addr,
    input  logic          reg_we,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          irq_out
);
    logic [N-1:0]  lvl_sync;
    logic [N-1:0]  mask_q;
    logic [N-1:0]  pend;
    logic [DW-1:0] vec;
    reg_sel_e      sel;
    logic          mask_wr;

    irq_sync_bank #(.WIDTH(N), .STAGES(SYNC_STG)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(irq_in), .sync_out(lvl_sync)
    );

    irq_mask_reg #(.WIDTH(N), .RST_VAL(N'(MASK_RST))) u_mask (
        .clk(clk), .rst_n(rst_n), .wr_en(mask_wr),
        .wr_data(reg_wdata[N-1:0]), .mask_q(mask_q)
    );

    irq_vec_enc #(.N(N), .OUT_W(DW), .SHL(VEC_SHL)) u_enc (
        .req(pend), .vec(vec)
    );

    // Decode the offset into a register select
    always_comb begin
        if (reg_addr == VEC_OFF)       sel = SEL_VEC;
        else if (reg_addr == MASK_OFF) sel = SEL_MASK;
        else                           sel = SEL_NONE;
    end

    assign mask_wr = reg_we && (sel == SEL_MASK);
    assign pend    = lvl_sync & mask_q;
    assign irq_out = |pend;

    // Read mux; offsets that are not decoded return zero
    always_comb begin
        case (sel)
            SEL_VEC:  reg_rdata = vec;
            SEL_MASK: reg_rdata = DW'(mask_q);
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
// Property checker for irq_vector_ctrl, attached with bind.
// Assumes the default two-stage synchronizer.
module irq_vector_ctrl_chk #(
    parameter int unsigned N  = 16,
    parameter int unsigned DW = 16,
    parameter int unsigned AW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic [N-1:0]  irq_in,
    input logic [AW-1:0] reg_addr,
    input logic          reg_we,
    input logic [DW-1:0] reg_wdata,
    input logic          irq_out,
    input logic [N-1:0]  mask_q,
    input logic [N-1:0]  lvl_sync,
    input logic [DW-1:0] vec
);
    logic       seen_clk;
    logic [1:0] run_cnt;

    // Mark that at least one edge has passed, so that $past is meaningful
    always_ff @(posedge clk) seen_clk <= 1'b1;

    // Count the cycles since reset, saturating at two
    always_ff @(posedge clk) begin
        if (!rst_n)              run_cnt <= '0;
        else if (run_cnt != 2'd2) run_cnt <= run_cnt + 2'd1;
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        (seen_clk === 1'b1 && !$past(rst_n)) |-> (mask_q == N'(16'h0010) && !irq_out));

    assert_out_vs_vec_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == (vec != '0));

    assert_vec_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (vec[1:0] == 2'b00) && (vec <= DW'(N << 2)));

    assert_mask_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 12'h002) |=> (mask_q == $past(reg_wdata[N-1:0])));

    assert_mask_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_addr == 12'h002) |=> $stable(mask_q));

    assert_sync_delay_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (run_cnt == 2'd2) |-> (lvl_sync == $past(irq_in, 2)));
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(.N(N), .DW(DW), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_addr(reg_addr),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .irq_out(irq_out),
    .mask_q(mask_q), .lvl_sync(lvl_sync), .vec(vec)
);

// File: tb/tb_irq_vector_ctrl.sv
// Self-checking bench: a table walk, then directed cases for reset, latency and decode.
module tb_irq_vector_ctrl;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] irq_in;
    logic [11:0] reg_addr;
    logic        reg_we;
    logic [15:0] reg_wdata;
    logic [15:0] reg_rdata;
    logic        irq_out;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    irq_vector_ctrl dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_addr(reg_addr),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_out(irq_out)
    );

    localparam int NV = 10;
    localparam logic [15:0] T_IN   [NV] = '{16'h0000, 16'h0001, 16'h8000, 16'h8001, 16'hFFFF,
                                            16'h00F0, 16'h0C00, 16'h0300, 16'hFFFF, 16'h1234};
    localparam logic [15:0] T_MASK [NV] = '{16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFE, 16'h0010,
                                            16'h0000, 16'h0800, 16'h0200, 16'hFFFF, 16'h0030};
    localparam logic [15:0] T_VEC  [NV] = '{16'h0000, 16'h0004, 16'h0040, 16'h0040, 16'h0014,
                                            16'h0000, 16'h0030, 16'h0028, 16'h0004, 16'h0014};
    localparam logic        T_OUT  [NV] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1,
                                            1'b0, 1'b1, 1'b1, 1'b1, 1'b1};

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    // Drive an address at a falling edge and sample the read data 1 ns later
    task automatic rd(input logic [11:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        reg_we   = 1'b0;
        #1;
        d = reg_rdata;
    endtask

    // Drive a one-cycle write at a falling edge
    task automatic wr(input logic [11:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    initial begin
        logic [15:0] d;
        rst_n = 1'b0; irq_in = '0; reg_addr = '0; reg_we = 1'b0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: state after reset
        rd(12'h002, d); check("R1 mask", d, 16'h0010);
        rd(12'h000, d); check("R1 vec", d, 16'h0000);
        check("R1 irq_out", {15'd0, irq_out}, 16'h0000);

        // Table walk: R3, R4, R5, R6
        for (int k = 0; k < NV; k++) begin
            wr(12'h002, T_MASK[k]);
            irq_in = T_IN[k];
            repeat (3) @(negedge clk);
            rd(12'h000, d); check("R4/R5 vec", d, T_VEC[k]);
            rd(12'h002, d); check("R6 mask readback", d, T_MASK[k]);
            check("R3 irq_out", {15'd0, irq_out}, {15'd0, T_OUT[k]});
        end

        // R2: releasing the input clears pending state
        wr(12'h002, 16'hFFFF);
        irq_in = 16'h0008;
        repeat (3) @(negedge clk);
        rd(12'h000, d); check("R2 pending set", d, 16'h0010);
        irq_in = 16'h0000;
        repeat (3) @(negedge clk);
        rd(12'h000, d); check("R2 released", d, 16'h0000);
        check("R2 irq_out low", {15'd0, irq_out}, 16'h0000);

        // R9: two-edge latency from the input to irq_out
        @(negedge clk); irq_in = 16'h0100;
        @(negedge clk); check("R9 after one edge", {15'd0, irq_out}, 16'h0000);
        @(negedge clk); check("R9 after two edges", {15'd0, irq_out}, 16'h0001);

        // R6: a mask write takes effect in the cycle after the write edge
        @(negedge clk);
        reg_addr = 12'h002; reg_wdata = 16'h0000; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
        check("R6 cleared mask drops irq", {15'd0, irq_out}, 16'h0000);
        @(negedge clk);
        reg_addr = 12'h002; reg_wdata = 16'h0100; reg_we = 1'b1;
        check("R6 before write edge", {15'd0, irq_out}, 16'h0000);
        @(negedge clk);
        reg_we = 1'b0;
        check("R6 after write edge", {15'd0, irq_out}, 16'h0001);

        // R8: repeated vector reads change nothing
        for (int k = 0; k < 4; k++) begin
            rd(12'h000, d); check("R8 repeat read", d, 16'h0024);
        end
        check("R8 irq_out kept", {15'd0, irq_out}, 16'h0001);

        // R7: offsets that are not decoded, and the read-only vector
        wr(12'h004, 16'hFFFF);
        wr(12'h000, 16'h0000);
        wr(12'h003, 16'h0000);
        rd(12'h002, d); check("R7 mask unchanged", d, 16'h0100);
        rd(12'h000, d); check("R7 vec unchanged", d, 16'h0024);
        rd(12'h004, d); check("R7 read 0x004", d, 16'h0000);
        rd(12'h001, d); check("R7 read 0x001", d, 16'h0000);
        rd(12'hFFE, d); check("R7 read 0xFFE", d, 16'h0000);

        // R1: reset in the middle of a run with inputs high
        irq_in = 16'hFFEF;
        wr(12'h002, 16'hFFFF);
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 irq_out after reset", {15'd0, irq_out}, 16'h0000);
        rd(12'h002, d); check("R1 mask after reset", d, 16'h0010);
        repeat (3) @(negedge clk);
        rd(12'h000, d); check("R1 reset mask blocks other sources", d, 16'h0000);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: end a hung run and count it as a failure
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule